// File: doc/BRIEF.md
# Multi-Channel Interval Timer

This block measures, for each of several channel inputs, the number of clock cycles between a falling edge on that channel and a falling edge on one shared reference input. The count is turned into a 12-bit code through a programmable full-scale value. The code runs from 0 to 3840. A larger full-scale value spreads the same range over more cycles, so a given interval gives a smaller code. Each channel also reports a valid flag and an overflow flag.

The block has two modes. In common-start mode, a reference fall opens one measurement window for all channels, and the first fall on each channel closes that channel's interval. In common-stop mode, each channel fall opens that channel's own interval, and the next reference fall closes all intervals at once. In both modes, all channel results are loaded into the output registers together, and a single one-cycle `done` pulse marks the end of each event.

All inputs are synchronous to `clk`. An edge is seen when an input was high at one clock edge and is low at the next. The mode and full-scale value are plain inputs. The block takes them in only while it is idle.

Top module: `interval_timer`

## Requirements
- R1: In common-start mode (`cfg_stop`=0), a reference fall seen while idle opens a window. A channel fall seen d clock edges later gives elapsed = d. A channel fall seen on the same edge as the reference fall gives elapsed = 0. Only the first fall per channel counts.
- R2: In common-stop mode (`cfg_stop`=1), a channel fall arms that channel. The next reference fall gives elapsed = the number of clock edges from the channel fall to the reference fall (0 if both fall on the same edge). A later fall on an already armed channel restarts its count.
- R3: With FS the effective full scale, the code is floor(elapsed*3840/FS), limited to 3840. `ovf` is 1 exactly when elapsed > FS. Elapsed = FS gives code 3840 with `ovf`=0.
- R4: The capture window is 2*FS cycles. In start mode, the window closes 2*FS edges after the start edge. In stop mode, a channel whose fall came more than 2*FS edges before the reference fall is dropped. A channel without a capture reports valid=0, code=0 and ovf=0.
- R5: `done` is high for exactly one cycle. It follows the edge that closes the window: the reference-fall edge in stop mode, or the edge 2*FS after the start edge in start mode. The results change only on that edge and hold until the next event.
- R6: In start mode, a reference fall that arrives while a window is open is ignored. It neither restarts nor stretches the window.
- R7: `cfg_stop` and `cfg_fs` are taken in only while idle: no open window, and no armed channel in stop mode. A change made during a measurement applies from the next event.
- R8: A full-scale value of 0 is treated as 1.
- R9: After reset, `done`, every `result_valid` bit, every `result_ovf` bit and every code are 0.
- R10: In stop mode, a reference fall with no channel armed still produces a `done` pulse, with every channel invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Shared reference input, active on its falling edge |
| hit_in | input | NCH | Channel inputs, active on their falling edges |
| cfg_stop | input | 1 | Mode select: 0 = common start, 1 = common stop |
| cfg_fs | input | FS_W | Full-scale value in clock cycles |
| result_code | output | NCH*12 | 12-bit code per channel; channel i is at bits [12*i+11:12*i] |
| result_valid | output | NCH | Channel captured an interval in the last event |
| result_ovf | output | NCH | Channel interval exceeded full scale |
| done | output | 1 | One-cycle pulse when new results are loaded |

## Verification
The bench targets the code boundaries around full scale:
- Elapsed equal to FS must give code 3840 with no overflow. A design that used >= for overflow would wrongly flag it.
- Elapsed equal to 2*FS must still be valid. A window that is one cycle short would report it invalid.

It also checks that each result lands exactly when it should:
- Same-edge falls must give elapsed 0.
- `done` must appear exactly 2*FS+1 falling clock edges after the reference fall in start mode. An off-by-one counter shows up in every code and in the `done` timing.

A reference fall inside an open window must leave the window length unchanged. A full-scale change during a window must not alter that event's codes; a design that sampled the configuration continuously would report different codes. Finally, the bench checks the stop-mode corner cases:
- a dropped channel whose fall came too early;
- a re-armed channel, which must report the later fall;
- an empty event, which must still pulse `done`.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int CODE_W   = 12;
  localparam int CODE_MAX = 3840;

  // Returns {overflow, code} for an elapsed count against full scale fs (fs >= 1).
  function automatic logic [CODE_W:0] scale_code(input logic [31:0] el, input logic [31:0] fs);
    logic [31:0] q;
    if (el > fs) return {1'b1, CODE_W'(CODE_MAX)};
    q = (el * 32'(CODE_MAX)) / fs;
    return {1'b0, q[CODE_W-1:0]};
  endfunction
endpackage

// File: rtl/fall_detect.sv
module fall_detect #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  assign fall = prev_q & ~din;
endmodule

// File: rtl/tdc_ctrl.sv
module tdc_ctrl #(
  parameter int FS_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_fall,
  input  logic          any_armed,
  input  logic          cfg_stop,
  input  logic [FS_W-1:0] cfg_fs,
  output logic          mode_stop,
  output logic [FS_W-1:0] fs_eff,
  output logic [FS_W:0] win_end,
  output logic [FS_W:0] cnt,
  output logic          run,
  output logic          start_evt,
  output logic          close_evt
);
  localparam int CW = FS_W + 1;

  logic [FS_W-1:0] fs_q;
  logic            idle;
  logic            end_evt;

  assign fs_eff    = (fs_q == '0) ? FS_W'(1) : fs_q;
  assign win_end   = {fs_eff, 1'b0};
  assign idle      = mode_stop ? !any_armed : !run;
  assign start_evt = !mode_stop && !run && ref_fall;
  assign end_evt   = run && (cnt == win_end);
  assign close_evt = mode_stop ? ref_fall : end_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      cnt       <= '0;
      mode_stop <= 1'b0;
      fs_q      <= '0;
    end else begin
      if (idle) begin
        mode_stop <= cfg_stop;
        fs_q      <= cfg_fs;
      end
      if (start_evt) begin
        run <= 1'b1;
        cnt <= CW'(1);
      end else if (end_evt) begin
        run <= 1'b0;
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdc_lane.sv
module tdc_lane
  import tdc_pkg::*;
#(
  parameter int FS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_stop,
  input  logic              hit_fall,
  input  logic              start_evt,
  input  logic              run,
  input  logic              close_evt,
  input  logic [FS_W:0]     shared_cnt,
  input  logic [FS_W:0]     win_end,
  input  logic [FS_W-1:0]   fs_eff,
  output logic              armed,
  output logic              snap_valid,
  output logic              snap_ovf,
  output logic [CODE_W-1:0] snap_code
);
  localparam int CW = FS_W + 1;

  logic          got_q;
  logic [CW-1:0] el_q;
  logic [CW-1:0] own_cnt;
  logic [CW-1:0] snap_el;
  logic [CODE_W:0] scaled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got_q   <= 1'b0;
      el_q    <= '0;
      own_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      // common-start capture against the shared window counter
      if (start_evt) begin
        got_q <= hit_fall;
        el_q  <= '0;
      end else if (run && hit_fall && !got_q) begin
        got_q <= 1'b1;
        el_q  <= shared_cnt;
      end
      // common-stop: per-channel counter opened by the channel fall
      if (!mode_stop || close_evt) begin
        armed <= 1'b0;
      end else if (hit_fall) begin
        armed   <= 1'b1;
        own_cnt <= CW'(1);
      end else if (armed) begin
        if (own_cnt == win_end) armed   <= 1'b0;
        else                    own_cnt <= own_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (mode_stop) begin
      snap_valid = hit_fall || armed;
      snap_el    = hit_fall ? '0 : own_cnt;
    end else begin
      snap_valid = got_q || hit_fall;
      snap_el    = got_q ? el_q : shared_cnt;
    end
    scaled    = scale_code(32'(snap_el), 32'(fs_eff));
    snap_ovf  = snap_valid && scaled[CODE_W];
    snap_code = snap_valid ? scaled[CODE_W-1:0] : '0;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tdc_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int FS_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ref_in,
  input  logic [NCH-1:0]        hit_in,
  input  logic                  cfg_stop,
  input  logic [FS_W-1:0]       cfg_fs,
  output logic [NCH*CODE_W-1:0] result_code,
  output logic [NCH-1:0]        result_valid,
  output logic [NCH-1:0]        result_ovf,
  output logic                  done
);
  logic [NCH:0]        falls;
  logic                ref_fall;
  logic [NCH-1:0]      hit_fall;
  logic                mode_stop;
  logic [FS_W-1:0]     fs_eff;
  logic [FS_W:0]       win_end;
  logic [FS_W:0]       cnt;
  logic                run;
  logic                start_evt;
  logic                close_evt;
  logic [NCH-1:0]      armed_vec;
  logic [NCH-1:0]      snap_valid;
  logic [NCH-1:0]      snap_ovf;
  logic [NCH*CODE_W-1:0] snap_code;

  fall_detect #(.W(NCH + 1)) edge_i (
    .clk(clk), .rst_n(rst_n), .din({hit_in, ref_in}), .fall(falls)
  );
  assign ref_fall = falls[0];
  assign hit_fall = falls[NCH:1];

  tdc_ctrl #(.FS_W(FS_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ref_fall(ref_fall), .any_armed(|armed_vec),
    .cfg_stop(cfg_stop), .cfg_fs(cfg_fs), .mode_stop(mode_stop), .fs_eff(fs_eff),
    .win_end(win_end), .cnt(cnt), .run(run), .start_evt(start_evt), .close_evt(close_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    tdc_lane #(.FS_W(FS_W)) lane_i (
      .clk(clk), .rst_n(rst_n), .mode_stop(mode_stop), .hit_fall(hit_fall[i]),
      .start_evt(start_evt), .run(run), .close_evt(close_evt), .shared_cnt(cnt),
      .win_end(win_end), .fs_eff(fs_eff), .armed(armed_vec[i]),
      .snap_valid(snap_valid[i]), .snap_ovf(snap_ovf[i]),
      .snap_code(snap_code[i*CODE_W +: CODE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_code  <= '0;
      result_valid <= '0;
      result_ovf   <= '0;
      done         <= 1'b0;
    end else begin
      done <= close_evt;
      if (close_evt) begin
        result_code  <= snap_code;
        result_valid <= snap_valid;
        result_ovf   <= snap_ovf;
      end
    end
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk
  import tdc_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int FS_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  done,
  input logic                  run,
  input logic                  close_evt,
  input logic [FS_W-1:0]       fs_eff,
  input logic [NCH*CODE_W-1:0] result_code,
  input logic [NCH-1:0]        result_valid,
  input logic [NCH-1:0]        result_ovf
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_close_done_r5: assert property (@(posedge clk) disable iff (!rst_n) close_evt |=> done);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !close_evt |=> ($stable(result_valid) && $stable(result_code) && $stable(result_ovf)));
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !close_evt) |=> run);
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(fs_eff));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    p_ovf_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      result_ovf[i] |-> (result_valid[i] && result_code[i*CODE_W +: CODE_W] == CODE_W'(CODE_MAX)));
    p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      result_code[i*CODE_W +: CODE_W] <= CODE_W'(CODE_MAX));
    p_invalid_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid[i] |-> (!result_ovf[i] && result_code[i*CODE_W +: CODE_W] == '0));
  end
endmodule

bind interval_timer interval_timer_chk #(.NCH(NCH), .FS_W(FS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .run(run), .close_evt(close_evt),
  .fs_eff(fs_eff), .result_code(result_code), .result_valid(result_valid),
  .result_ovf(result_ovf)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb_top;
  localparam int CLK_P = 10;
  localparam int NCH   = 4;
  localparam int FS_W  = 16;
  localparam int NVEC  = 6;
  // columns: mode (0 start, 1 stop), full scale, then per-channel delay (-1 = none)
  localparam int VEC [NVEC][6] = '{
    '{0, 10,  3,  0, 10, -1},
    '{0, 10, 11, 20,  7,  1},
    '{0,  7,  5,  1, 14, -1},
    '{1, 10,  2,  0, 20, -1},
    '{1, 12, 21,  5, 12, 24},
    '{1,  9, 19,  3, -1, 18}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_in = 1'b1;
  logic [NCH-1:0]    hit_in = '1;
  logic              cfg_stop = 1'b0;
  logic [FS_W-1:0]   cfg_fs = '0;
  logic [NCH*12-1:0] result_code;
  logic [NCH-1:0]    result_valid;
  logic [NCH-1:0]    result_ovf;
  logic              done;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  interval_timer #(.NCH(NCH), .FS_W(FS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .hit_in(hit_in), .cfg_stop(cfg_stop),
    .cfg_fs(cfg_fs), .result_code(result_code), .result_valid(result_valid),
    .result_ovf(result_ovf), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected {valid, ovf, code} packed as valid<<13 | ovf<<12 | code
  function automatic int exp_word(input int el, input int fs);
    int fse = (fs == 0) ? 1 : fs;
    int code;
    if (el < 0 || el > 2 * fse) return 0;
    if (el > fse) return (1 << 13) | (1 << 12) | 3840;
    code = (el * 3840) / fse;
    return (1 << 13) | code;
  endfunction

  function automatic int act_word(input int i);
    return (int'(result_valid[i]) << 13) | (int'(result_ovf[i]) << 12) | int'(result_code[i*12 +: 12]);
  endfunction

  task automatic set_cfg(input logic stop, input int fs);
    @(negedge clk);
    cfg_stop = stop;
    cfg_fs   = FS_W'(fs);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_event(input string tag);
    @(negedge clk);
    chk({tag, " R5 done single cycle"}, int'(done), 0);
    ref_in = 1'b1;
    hit_in = '1;
    repeat (3) @(negedge clk);
  endtask

  // common-start event: ref falls at step 0, channel i falls at step d[i]
  task automatic run_start(input int fs, input int d [NCH], input int refup, input int refdn,
                           input int fschg, input int fsnew, input string tag);
    int fse = (fs == 0) ? 1 : fs;
    int w = 2 * fse;
    int jdone = -1;
    @(negedge clk);
    ref_in = 1'b0;
    for (int i = 0; i < NCH; i++) if (d[i] == 0) hit_in[i] = 1'b0;
    for (int j = 1; j <= w + 5 && jdone < 0; j++) begin
      @(negedge clk);
      if (done) jdone = j;
      else begin
        if (refup == j) ref_in = 1'b1;
        if (refdn == j) ref_in = 1'b0;
        if (fschg == j) cfg_fs = FS_W'(fsnew);
        for (int i = 0; i < NCH; i++) if (d[i] == j) hit_in[i] = 1'b0;
      end
    end
    chk({tag, " R5/R4 done step"}, jdone, w + 1);
    for (int i = 0; i < NCH; i++) chk({tag, " R1/R3 channel result"}, act_word(i), exp_word(d[i], fs));
    finish_event(tag);
  endtask

  // common-stop event: channel i falls a[i] steps before the ref fall
  task automatic run_stop(input int fs, input int a [NCH], input string tag);
    int t = 0;
    for (int i = 0; i < NCH; i++) if (a[i] > t) t = a[i];
    for (int j = 0; j <= t; j++) begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) if (a[i] >= 0 && a[i] == t - j) hit_in[i] = 1'b0;
      if (j == t) ref_in = 1'b0;
    end
    @(negedge clk);
    chk({tag, " R5 done after ref fall"}, int'(done), 1);
    for (int i = 0; i < NCH; i++) chk({tag, " R2/R3/R4 channel result"}, act_word(i), exp_word(a[i], fs));
    finish_event(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 done after reset", int'(done), 0);
    chk("R9 valid after reset", int'(result_valid), 0);
    chk("R9 ovf after reset", int'(result_ovf), 0);
    chk("R9 codes after reset", int'(result_code[31:0]) | int'(result_code[47:32]), 0);

    for (int v = 0; v < NVEC; v++) begin
      int d [NCH];
      for (int i = 0; i < NCH; i++) d[i] = VEC[v][2 + i];
      set_cfg(VEC[v][0] != 0, VEC[v][1]);
      if (VEC[v][0] == 0) run_start(VEC[v][1], d, -1, -1, -1, 0, $sformatf("vec%0d", v));
      else                run_stop(VEC[v][1], d, $sformatf("vec%0d", v));
    end

    // R6: ref rises and falls again inside the window
    set_cfg(1'b0, 10);
    run_start(10, '{8, -1, -1, -1}, 3, 5, -1, 0, "R6 ref refall ignored");

    // R7: full scale changed mid-window, applies to next event only
    run_start(10, '{10, 4, -1, -1}, -1, -1, 2, 20, "R7 old fs kept");
    run_start(20, '{10, 40, -1, -1}, -1, -1, -1, 0, "R7 new fs used");

    // R8: zero full scale acts as one
    set_cfg(1'b0, 0);
    run_start(0, '{1, 2, 0, -1}, -1, -1, -1, 0, "R8 zero fs");

    // R10: stop-mode ref with nothing armed
    set_cfg(1'b1, 10);
    run_stop(10, '{-1, -1, -1, -1}, "R10 empty event");

    // R2: re-armed channel reports the later fall
    for (int j = 0; j <= 8; j++) begin
      @(negedge clk);
      if (j == 0) hit_in[0] = 1'b0;
      if (j == 2) hit_in[0] = 1'b1;
      if (j == 5) hit_in[0] = 1'b0;
      if (j == 8) ref_in = 1'b0;
    end
    @(negedge clk);
    chk("R2 restart done", int'(done), 1);
    chk("R2 restart channel0", act_word(0), exp_word(3, 10));
    chk("R2 restart channel1", act_word(1), 0);
    finish_event("R2 restart");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R5 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule